// File: doc/BRIEF.md
# Pipeline Interlock Controller

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It does not carry data: every pin is plain control. Each cycle it looks at the operands read by the instruction in decode and at the destinations of the instructions in execute, memory and writeback. From these it picks a bypass source for each operand, decides whether the front of the pipeline must wait, and tells the datapath where to insert empty slots.

ALU results reach a dependent instruction with no wait. A load costs a wait only when a later instruction actually reads the loaded register before the data exists; unrelated instructions keep moving. A multiply that is still computing freezes the whole pipeline. A taken branch, resolved in decode, redirects fetch. Its single delay-slot instruction is already in fetch and always runs, so the block has no squash output. An instruction whose condition evaluated false counts as having no destination.

The block is purely combinational. The clock and the active-low reset are used only by the embedded checks.

Top module: `pipe_interlock`

## Requirements
- R1: For each operand, `opnd_sel` is set by the youngest matching producer. The encoding is 0 for register file, 1 for execute result, 2 for memory-stage result and 3 for writeback result. Priority runs execute, then memory, then writeback.
- R2: Register 0 never selects a bypass source and never causes a stall.
- R3: A producer whose condition flag is low is ignored. It is never a bypass source and never a stall cause, so an older matching producer is chosen instead.
- R4: A load in execute whose destination matches a read operand of decode raises the load-use stall. `hold_if` and `hold_id` go high and `bubble_ex` goes high; `hold_ex`, `hold_mem` and `bubble_wb` stay low. A load with no such reader causes nothing.
- R5: A load in the memory stage with a matching reader stalls as in R4 while `mem_ld_ready` is low. Once `mem_ld_ready` is high it is bypassed with select 2 and no stall.
- R6: A multiply in execute with its condition true while `mul_busy` is high freezes the pipeline. All four hold outputs and `bubble_wb` go high and `bubble_ex` stays low, even when a load-use stall is also present.
- R7: `redirect_en` follows `id_br_taken` only when decode advances, and is low whenever `hold_id` is high. A taken branch on its own never raises a hold or a bubble, so the delay-slot instruction is never squashed.
- R8: An operand whose read-enable bit is low never causes a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, used by the checks only |
| rst_n | input | 1 | Active-low reset, disables the checks |
| id_src | input | NSRC*RW | Source register numbers of the decode instruction |
| id_rd_en | input | NSRC | Per-operand read enable |
| id_br_taken | input | 1 | Decode instruction is a taken branch |
| ex_dst | input | RW | Execute-stage destination |
| ex_wen | input | 1 | Execute instruction writes a register |
| ex_cond_ok | input | 1 | Execute instruction's condition passed |
| ex_load | input | 1 | Execute instruction is a load |
| ex_mul | input | 1 | Execute instruction is a multiply |
| mul_busy | input | 1 | Multiplier result not ready yet |
| mem_dst | input | RW | Memory-stage destination |
| mem_wen | input | 1 | Memory instruction writes a register |
| mem_cond_ok | input | 1 | Memory instruction's condition passed |
| mem_load | input | 1 | Memory instruction is a load |
| mem_ld_ready | input | 1 | Load data has returned |
| wb_dst | input | RW | Writeback destination |
| wb_wen | input | 1 | Writeback instruction writes a register |
| wb_cond_ok | input | 1 | Writeback instruction's condition passed |
| opnd_sel | output | NSRC*2 | Per-operand bypass select |
| hold_if | output | 1 | Fetch keeps its contents |
| hold_id | output | 1 | Decode keeps its contents |
| hold_ex | output | 1 | Execute keeps its contents |
| hold_mem | output | 1 | Memory stage keeps its contents |
| bubble_ex | output | 1 | Insert a no-write slot into execute |
| bubble_wb | output | 1 | Insert a no-write slot into writeback |
| redirect_en | output | 1 | Load the branch target into fetch |

## Verification
The bench builds the block with NREG=8 and NSRC=3. With only eight registers, random destinations and sources collide often, so multi-producer priority cases and register-0 cases come up frequently without steering. A third operand exercises the generated per-operand logic beyond the default two, and lets a single cycle mix a stalled operand with operands that are bypassed normally.

// File: rtl/pil_pkg.sv
package pil_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'd0,
    SEL_EX  = 2'd1,
    SEL_MEM = 2'd2,
    SEL_WB  = 2'd3
  } opsel_e;
endpackage

// File: rtl/pil_fwd.sv
module pil_fwd
  import pil_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] src,
  input  logic          rd_en,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_live,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_live,
  input  logic          mem_pend,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_live,
  output opsel_e        sel,
  output logic          hazard
);
  logic reads, ex_hit, mem_hit, wb_hit;

  always_comb begin
    reads   = rd_en && (src != '0);
    ex_hit  = reads && ex_live  && (ex_dst  == src);
    mem_hit = reads && mem_live && (mem_dst == src);
    wb_hit  = reads && wb_live  && (wb_dst  == src);
    if (ex_hit)       sel = SEL_EX;
    else if (mem_hit) sel = SEL_MEM;
    else if (wb_hit)  sel = SEL_WB;
    else              sel = SEL_RF;
    hazard = (ex_hit && ex_load) || (!ex_hit && mem_hit && mem_pend);
  end

  // R1
  sel_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_EX) |-> (ex_live && ex_dst == src));
  // R2
  r0_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src == '0) |-> (sel == SEL_RF && !hazard));
  // R8
  unused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |-> !hazard);
endmodule

// File: rtl/pil_stall.sv
module pil_stall #(
  parameter int NSRC = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] hazards,
  input  logic            mul_wait,
  input  logic            br_taken,
  output logic            hold_if,
  output logic            hold_id,
  output logic            hold_ex,
  output logic            hold_mem,
  output logic            bubble_ex,
  output logic            bubble_wb,
  output logic            redirect_en
);
  logic load_use, front_hold;

  always_comb begin
    load_use    = |hazards;
    front_hold  = load_use || mul_wait;
    hold_if     = front_hold;
    hold_id     = front_hold;
    hold_ex     = mul_wait;
    hold_mem    = mul_wait;
    bubble_ex   = load_use && !mul_wait;
    bubble_wb   = mul_wait;
    redirect_en = br_taken && !front_hold;
  end

  // R6
  freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mul_wait |-> (hold_if && hold_id && hold_ex && hold_mem && bubble_wb && !bubble_ex));
  // R7
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_en |-> !hold_id);
  // R4
  bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |-> (hold_if && hold_id && !hold_ex && !bubble_wb));
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pil_pkg::*;
#(
  parameter int NREG = 32,
  parameter int NSRC = 2,
  localparam int RW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0][RW-1:0]  id_src,
  input  logic [NSRC-1:0]          id_rd_en,
  input  logic                     id_br_taken,
  input  logic [RW-1:0]            ex_dst,
  input  logic                     ex_wen,
  input  logic                     ex_cond_ok,
  input  logic                     ex_load,
  input  logic                     ex_mul,
  input  logic                     mul_busy,
  input  logic [RW-1:0]            mem_dst,
  input  logic                     mem_wen,
  input  logic                     mem_cond_ok,
  input  logic                     mem_load,
  input  logic                     mem_ld_ready,
  input  logic [RW-1:0]            wb_dst,
  input  logic                     wb_wen,
  input  logic                     wb_cond_ok,
  output logic [NSRC-1:0][1:0]     opnd_sel,
  output logic                     hold_if,
  output logic                     hold_id,
  output logic                     hold_ex,
  output logic                     hold_mem,
  output logic                     bubble_ex,
  output logic                     bubble_wb,
  output logic                     redirect_en
);
  // R3: a failed condition removes the destination
  logic ex_live, mem_live, wb_live, mem_pend, mul_wait;
  logic [NSRC-1:0] hazards;

  assign ex_live  = ex_wen  && ex_cond_ok;
  assign mem_live = mem_wen && mem_cond_ok;
  assign wb_live  = wb_wen  && wb_cond_ok;
  assign mem_pend = mem_load && !mem_ld_ready;
  assign mul_wait = ex_mul && ex_cond_ok && mul_busy;

  for (genvar g = 0; g < NSRC; g++) begin : g_opnd
    opsel_e sel_g;
    pil_fwd #(.RW(RW)) u_fwd (
      .clk(clk), .rst_n(rst_n),
      .src(id_src[g]), .rd_en(id_rd_en[g]),
      .ex_dst(ex_dst), .ex_live(ex_live), .ex_load(ex_load),
      .mem_dst(mem_dst), .mem_live(mem_live), .mem_pend(mem_pend),
      .wb_dst(wb_dst), .wb_live(wb_live),
      .sel(sel_g), .hazard(hazards[g])
    );
    assign opnd_sel[g] = sel_g;
  end

  pil_stall #(.NSRC(NSRC)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .hazards(hazards), .mul_wait(mul_wait), .br_taken(id_br_taken),
    .hold_if(hold_if), .hold_id(hold_id), .hold_ex(hold_ex),
    .hold_mem(hold_mem), .bubble_ex(bubble_ex), .bubble_wb(bubble_wb),
    .redirect_en(redirect_en)
  );

  // R3
  dead_ex_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ex_cond_ok && !mem_live && !wb_live && !mul_busy) |-> (!hold_if && opnd_sel == '0));
endmodule

// File: tb/pipe_interlock_test.sv
module pipe_interlock_test;
  localparam int NR = 8;
  localparam int NS = 3;
  localparam int RW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NS-1:0][RW-1:0] id_src;
  logic [NS-1:0] id_rd_en;
  logic id_br_taken, ex_wen, ex_cond_ok, ex_load, ex_mul, mul_busy;
  logic mem_wen, mem_cond_ok, mem_load, mem_ld_ready, wb_wen, wb_cond_ok;
  logic [RW-1:0] ex_dst, mem_dst, wb_dst;
  logic [NS-1:0][1:0] opnd_sel;
  logic hold_if, hold_id, hold_ex, hold_mem, bubble_ex, bubble_wb, redirect_en;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  pipe_interlock #(.NREG(NR), .NSRC(NS)) uut (.*);

  // expected {hazard, sel} for one operand, from R1/R2/R3/R5/R8
  function automatic logic [2:0] exp_opnd(input int k);
    logic r, e, m, w;
    r = id_rd_en[k] && id_src[k] != 0;
    e = r && ex_wen && ex_cond_ok && ex_dst == id_src[k];
    m = r && mem_wen && mem_cond_ok && mem_dst == id_src[k];
    w = r && wb_wen && wb_cond_ok && wb_dst == id_src[k];
    if (e)      return {ex_load, 2'd1};
    else if (m) return {mem_load && !mem_ld_ready, 2'd2};
    else if (w) return {1'b0, 2'd3};
    return 3'd0;
  endfunction

  task automatic check_all(input string tag);
    logic [NS-1:0][1:0] es;
    logic lu, fr;
    logic [6:0] ectl, actl;
    lu = 0;
    for (int k = 0; k < NS; k++) begin
      logic [2:0] v;
      v = exp_opnd(k);
      es[k] = v[1:0];
      lu |= v[2];
    end
    fr = ex_mul && ex_cond_ok && mul_busy;
    ectl = {lu || fr, lu || fr, fr, fr, lu && !fr, fr, id_br_taken && !(lu || fr)};
    actl = {hold_if, hold_id, hold_ex, hold_mem, bubble_ex, bubble_wb, redirect_en};
    checks++;
    if (actl !== ectl || (!(lu || fr) && opnd_sel !== es)) begin
      errors++;
      $display("FAIL %s ctl=%b exp %b sel=%h exp %h", tag, actl, ectl, opnd_sel, es);
    end
  endtask

  task automatic idle();
    id_src = '0; id_rd_en = '0; id_br_taken = 0;
    ex_dst = 0; ex_wen = 0; ex_cond_ok = 1; ex_load = 0; ex_mul = 0; mul_busy = 0;
    mem_dst = 0; mem_wen = 0; mem_cond_ok = 1; mem_load = 0; mem_ld_ready = 0;
    wb_dst = 0; wb_wen = 0; wb_cond_ok = 1;
  endtask

  task automatic step(input string tag);
    #1;
    check_all(tag);
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd2024));
    idle();
    repeat (3) @(negedge clk);
    step("reset R1");
    rst_n = 1'b1;
    @(negedge clk);
    // R1 priority
    id_src[0] = 3'd4; id_rd_en = 3'b001;
    ex_dst = 4; ex_wen = 1; mem_dst = 4; mem_wen = 1; wb_dst = 4; wb_wen = 1;
    step("R1 ex first");
    ex_wen = 0; step("R1 mem next");
    mem_wen = 0; step("R1 wb last");
    // R2 register 0
    idle(); id_rd_en = 3'b111; ex_wen = 1; ex_load = 1; ex_dst = 0; step("R2 r0");
    // R3 failed condition
    idle(); id_src[1] = 3'd5; id_rd_en = 3'b010;
    ex_dst = 5; ex_wen = 1; ex_load = 1; ex_cond_ok = 0; mem_dst = 5; mem_wen = 1; mem_ld_ready = 1;
    step("R3 skip ex");
    mem_cond_ok = 0; step("R3 nothing");
    // R4 load-use
    idle(); id_src[2] = 3'd6; id_rd_en = 3'b100; ex_dst = 6; ex_wen = 1; ex_load = 1;
    step("R4 use");
    ex_dst = 2; step("R4 independent");
    // R5 memory-stage load
    idle(); id_src[0] = 3'd3; id_rd_en = 3'b001; mem_dst = 3; mem_wen = 1; mem_load = 1;
    step("R5 pending");
    mem_ld_ready = 1; step("R5 ready");
    // R6 multiply freeze
    idle(); ex_mul = 1; mul_busy = 1; step("R6 freeze");
    id_src[0] = 3'd1; id_rd_en = 3'b001; ex_dst = 1; ex_wen = 1; ex_load = 1; step("R6 over load");
    idle(); ex_mul = 1; mul_busy = 1; ex_cond_ok = 0; step("R6 cond false");
    // R7 branch and delay slot
    idle(); id_br_taken = 1; step("R7 redirect");
    id_src[1] = 3'd2; id_rd_en = 3'b010; ex_dst = 2; ex_wen = 1; ex_load = 1; step("R7 held");
    // R8 unused operand
    idle(); id_src[0] = 3'd7; ex_dst = 7; ex_wen = 1; ex_load = 1; step("R8 unused");
    // random streams
    for (int i = 0; i < 600; i++) begin
      {id_src, id_rd_en, id_br_taken} = $urandom;
      {ex_dst, ex_wen, ex_cond_ok, ex_load, ex_mul, mul_busy} = $urandom;
      {mem_dst, mem_wen, mem_cond_ok, mem_load, mem_ld_ready} = $urandom;
      {wb_dst, wb_wen, wb_cond_ok} = $urandom;
      mul_busy = mul_busy && ($urandom_range(3) == 0);
      step("R1 R3 R4 R5 R6 R7 random");
    end
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000 && !done; c++) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule